// File: doc/BRIEF.md
# Per-Core Interrupt Signalling Interface

This block connects an interrupt distributor to one processor core. Each cycle the distributor presents its best candidate for the core: a valid flag, an interrupt number and a priority value. The block compares that priority with a programmable threshold and checks a local enable. If both allow it and no interrupt is already being serviced, it raises a request line to the core.

The core's handler performs an acknowledge read, which returns the interrupt number. If nothing can be delivered at that moment, the read returns the reserved number 1023 instead. A successful acknowledge also sends a one-cycle notice to the distributor so the interrupt can be marked active. From then on the block raises no further request until the handler writes the same number to the completion port. A matching completion sends a one-cycle notice to the distributor and re-opens signalling. A completion carrying any other number has no effect.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the enable is off, the threshold is 0, `irq` is low, `ack_rdata` holds 1023, and both distributor notices are low.
- R2: While the enable is off, `irq` stays low whatever candidate is presented.
- R3: A candidate is deliverable only when its priority value is strictly below the threshold. An equal value blocks it, and a threshold of 0 blocks every candidate.
- R4: `irq` is a registered output. It goes high in the first cycle after the cycle in which the enable, the threshold and a valid candidate all allow delivery.
- R5: An acknowledge read of a deliverable candidate returns its number on `ack_rdata` in the next cycle. In that same cycle `dist_ack_vld` pulses with that number on `dist_ack_id`, and `irq` is low.
- R6: An acknowledge read when no candidate is deliverable returns 1023 and produces no `dist_ack_vld` pulse. This covers a candidate that is invalid and one that is blocked by the threshold.
- R7: After a successful acknowledge, `irq` stays low and further acknowledge reads return 1023 until a matching completion arrives.
- R8: A completion write carrying the active number pulses `dist_eoi_vld` with that number in the next cycle. If a candidate is still deliverable, `irq` rises one cycle after that.
- R9: A completion write carrying a different number is ignored. There is no `dist_eoi_vld` pulse, `irq` stays low, and an acknowledge read still returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_vld | input | 1 | Distributor presents a candidate |
| cand_id | input | 10 | Candidate interrupt number |
| cand_prio | input | 8 | Candidate priority value (lower is more urgent) |
| en_we | input | 1 | Write strobe for the enable |
| en_wdata | input | 1 | New enable value |
| thr_we | input | 1 | Write strobe for the priority threshold |
| thr_wdata | input | 8 | New threshold value |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_rdata | output | 10 | Result of the last acknowledge read |
| eoi_we | input | 1 | Completion write strobe |
| eoi_wdata | input | 10 | Number being completed |
| irq | output | 1 | Interrupt request to the core |
| dist_ack_vld | output | 1 | Acknowledge notice to the distributor |
| dist_ack_id | output | 10 | Number acknowledged |
| dist_eoi_vld | output | 1 | Completion notice to the distributor |
| dist_eoi_id | output | 10 | Number completed |

## Verification
Candidates are tried with the enable off and on, with a priority equal to the threshold, one step below it, and with a threshold of 0. This separates a strict comparison from a non-strict one, and an enable check from none. Acknowledge reads are issued with a deliverable candidate, with no valid candidate, with a threshold-blocked candidate, and again while one interrupt is still being serviced. This distinguishes the real number from the spurious 1023 and shows whether the one-at-a-time lock holds. Completions are sent with a wrong number and then with the right one, which tells an ignored write from a release and confirms when `irq` reappears.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    parameter int ID_W   = 10;
    parameter int PRIO_W = 8;

    typedef logic [ID_W-1:0]   id_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam id_t SPURIOUS_ID = '1;

    typedef enum logic {HS_IDLE, HS_BUSY} hs_state_e;

    typedef struct packed {
        logic  vld;
        id_t   id;
        prio_t prio;
    } cand_t;

    typedef struct packed {
        logic vld;
        id_t  id;
    } note_t;

    function automatic logic prio_beats_thr(prio_t p, prio_t thr);
        return p < thr;
    endfunction
endpackage

// File: rtl/cpuif_cfg.sv
module cpuif_cfg
    import cpuif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_we,
    input  logic  en_wdata,
    input  logic  thr_we,
    input  prio_t thr_wdata,
    output logic  en_q,
    output prio_t thr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            thr_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (thr_we) thr_q <= thr_wdata;
        end
    end

    // R3: the threshold changes only through its write strobe
    a_r3_thr_hold: assert property (@(posedge clk) disable iff (rst)
        !thr_we |=> $stable(thr_q));
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate
    import cpuif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  prio_t thr,
    input  cand_t cand,
    input  logic  busy,
    input  logic  ack_rd,
    output logic  deliver,
    output logic  irq
);
    always_comb begin
        deliver = en && cand.vld && !busy && prio_beats_thr(cand.prio, thr);
    end

    always_ff @(posedge clk) begin
        if (rst)         irq <= 1'b0;
        else if (ack_rd) irq <= 1'b0;
        else             irq <= deliver;
    end

    a_r2_off_blocks: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);
    a_r3_strict_thr: assert property (@(posedge clk) disable iff (rst)
        (cand.vld && cand.prio >= thr) |=> !irq);
    a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> !irq);
endmodule

// File: rtl/cpuif_hs.sv
module cpuif_hs
    import cpuif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ack_rd,
    input  logic  deliver,
    input  id_t   cand_id,
    input  logic  eoi_we,
    input  id_t   eoi_id,
    output logic  busy,
    output id_t   rdata,
    output note_t ack_note,
    output note_t eoi_note
);
    hs_state_e st_q;
    id_t       active_q;
    logic      eoi_hit;

    assign busy    = (st_q == HS_BUSY);
    assign eoi_hit = busy && eoi_we && (eoi_id == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= HS_IDLE;
            active_q <= SPURIOUS_ID;
            rdata    <= SPURIOUS_ID;
            ack_note <= '0;
            eoi_note <= '0;
        end else begin
            ack_note <= '0;
            eoi_note <= '0;
            if (ack_rd) begin
                if (deliver) begin
                    rdata    <= cand_id;
                    active_q <= cand_id;
                    st_q     <= HS_BUSY;
                    ack_note <= '{vld: 1'b1, id: cand_id};
                end else begin
                    rdata <= SPURIOUS_ID;
                end
            end else if (eoi_hit) begin
                st_q     <= HS_IDLE;
                eoi_note <= '{vld: 1'b1, id: active_q};
            end
        end
    end

    a_r5_ack_note_match: assert property (@(posedge clk) disable iff (rst)
        ack_note.vld |-> (rdata == ack_note.id));
    a_r6_spurious_no_note: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !deliver) |=> (!ack_note.vld && rdata == SPURIOUS_ID));
    a_r9_wrong_eoi_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack_rd && eoi_we && eoi_id != active_q) |=> (busy && !eoi_note.vld));
    a_r8_eoi_releases: assert property (@(posedge clk) disable iff (rst)
        eoi_note.vld |-> !busy);
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpuif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_vld,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              en_we,
    input  logic              en_wdata,
    input  logic              thr_we,
    input  logic [PRIO_W-1:0] thr_wdata,
    input  logic              ack_rd,
    output logic [ID_W-1:0]   ack_rdata,
    input  logic              eoi_we,
    input  logic [ID_W-1:0]   eoi_wdata,
    output logic              irq,
    output logic              dist_ack_vld,
    output logic [ID_W-1:0]   dist_ack_id,
    output logic              dist_eoi_vld,
    output logic [ID_W-1:0]   dist_eoi_id
);
    cand_t cand;
    logic  en_q, busy, deliver;
    prio_t thr_q;
    note_t ack_note, eoi_note;

    assign cand = '{vld: cand_vld, id: cand_id, prio: cand_prio};

    cpuif_cfg u_cfg (
        .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .en_q(en_q), .thr_q(thr_q)
    );

    cpuif_gate u_gate (
        .clk(clk), .rst(rst), .en(en_q), .thr(thr_q), .cand(cand),
        .busy(busy), .ack_rd(ack_rd), .deliver(deliver), .irq(irq)
    );

    cpuif_hs u_hs (
        .clk(clk), .rst(rst), .ack_rd(ack_rd), .deliver(deliver),
        .cand_id(cand_id), .eoi_we(eoi_we), .eoi_id(eoi_wdata),
        .busy(busy), .rdata(ack_rdata), .ack_note(ack_note), .eoi_note(eoi_note)
    );

    assign dist_ack_vld = ack_note.vld;
    assign dist_ack_id  = ack_note.id;
    assign dist_eoi_vld = eoi_note.vld;
    assign dist_eoi_id  = eoi_note.id;

    // R7: no request while an interrupt is in service
    a_r7_single_in_flight: assert property (@(posedge clk) disable iff (rst)
        busy |=> !irq);
    // R5: acknowledge and completion notices never coincide
    a_r5_notes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dist_ack_vld && dist_eoi_vld));
endmodule

// File: tb/tb_cpu_irq_iface.sv
module tb_cpu_irq_iface;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] SPUR = 10'd1023;

    logic       clk = 1'b0;
    logic       rst;
    logic       cand_vld;
    logic [9:0] cand_id;
    logic [7:0] cand_prio;
    logic       en_we, en_wdata, thr_we;
    logic [7:0] thr_wdata;
    logic       ack_rd;
    logic [9:0] ack_rdata;
    logic       eoi_we;
    logic [9:0] eoi_wdata;
    logic       irq, dist_ack_vld, dist_eoi_vld;
    logic [9:0] dist_ack_id, dist_eoi_id;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_iface dut (
        .clk(clk), .rst(rst), .cand_vld(cand_vld), .cand_id(cand_id),
        .cand_prio(cand_prio), .en_we(en_we), .en_wdata(en_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .ack_rd(ack_rd),
        .ack_rdata(ack_rdata), .eoi_we(eoi_we), .eoi_wdata(eoi_wdata),
        .irq(irq), .dist_ack_vld(dist_ack_vld), .dist_ack_id(dist_ack_id),
        .dist_eoi_vld(dist_eoi_vld), .dist_eoi_id(dist_eoi_id)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_en(logic v);
        en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
    endtask

    task automatic wr_thr(logic [7:0] v);
        thr_we = 1'b1; thr_wdata = v; tick(); thr_we = 1'b0;
    endtask

    task automatic do_ack();
        ack_rd = 1'b1; tick(); ack_rd = 1'b0;
    endtask

    task automatic do_eoi(logic [9:0] id);
        eoi_we = 1'b1; eoi_wdata = id; tick(); eoi_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cand_vld = 1'b1; cand_id = 10'd5; cand_prio = 8'd0;
        en_we = 0; en_wdata = 0; thr_we = 0; thr_wdata = 0;
        ack_rd = 0; eoi_we = 0; eoi_wdata = 0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        check("R1 irq", irq, 0);
        check("R1 ack_rdata", ack_rdata, SPUR);
        check("R1 dist_ack_vld", dist_ack_vld, 0);
        check("R1 dist_eoi_vld", dist_eoi_vld, 0);
        tick(); tick();
        check("R1 threshold 0 blocks, enable off", irq, 0);
    endtask

    task automatic t_enable();
        wr_thr(8'h80);
        cand_vld = 1'b1; cand_id = 10'd42; cand_prio = 8'h10;
        tick(); tick();
        check("R2 disabled keeps irq low", irq, 0);
        wr_en(1'b1);
        check("R4 irq not yet high in write cycle", irq, 0);
        tick();
        check("R4 irq high one cycle later", irq, 1);
    endtask

    task automatic t_threshold();
        cand_prio = 8'h80; tick(); tick();
        check("R3 equal priority blocked", irq, 0);
        cand_prio = 8'h7F; tick();
        check("R3 one below threshold passes", irq, 1);
        wr_thr(8'h00); tick();
        check("R3 threshold 0 blocks all", irq, 0);
        cand_prio = 8'h00; tick();
        check("R3 priority 0 vs threshold 0", irq, 0);
        wr_thr(8'h80); cand_prio = 8'h10;
    endtask

    task automatic t_spurious();
        cand_vld = 1'b0; tick();
        do_ack();
        check("R6 no candidate returns 1023", ack_rdata, SPUR);
        check("R6 no ack notice", dist_ack_vld, 0);
        cand_vld = 1'b1; cand_prio = 8'h90; tick();
        do_ack();
        check("R6 blocked candidate returns 1023", ack_rdata, SPUR);
        check("R6 blocked candidate no notice", dist_ack_vld, 0);
        cand_prio = 8'h10; tick();
        check("R4 irq back after unblock", irq, 1);
    endtask

    task automatic t_ack();
        cand_id = 10'd42;
        do_ack();
        check("R5 ack returns id", ack_rdata, 42);
        check("R5 ack notice", dist_ack_vld, 1);
        check("R5 ack notice id", dist_ack_id, 42);
        check("R5 irq low after ack", irq, 0);
        tick();
        check("R5 notice is one cycle", dist_ack_vld, 0);
        check("R7 irq stays low in service", irq, 0);
        cand_id = 10'd77; tick();
        check("R7 new candidate not signalled", irq, 0);
        do_ack();
        check("R7 second ack returns 1023", ack_rdata, SPUR);
        check("R7 second ack no notice", dist_ack_vld, 0);
    endtask

    task automatic t_eoi_wrong();
        do_eoi(10'd77);
        check("R9 wrong eoi no notice", dist_eoi_vld, 0);
        tick();
        check("R9 irq stays low", irq, 0);
        do_ack();
        check("R9 still locked, ack 1023", ack_rdata, SPUR);
    endtask

    task automatic t_eoi_right();
        do_eoi(10'd42);
        check("R8 eoi notice", dist_eoi_vld, 1);
        check("R8 eoi notice id", dist_eoi_id, 42);
        check("R8 irq low in eoi cycle", irq, 0);
        tick();
        check("R8 irq re-raised", irq, 1);
        check("R8 eoi notice is one cycle", dist_eoi_vld, 0);
        do_ack();
        check("R8 next ack returns new id", ack_rdata, 77);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_threshold();
        t_spurious();
        t_ack();
        t_eoi_wrong();
        t_eoi_right();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule